// File: doc/BRIEF.md
# Acknowledgement Tone Validator

This block decides whether a logic-level, already-demodulated acknowledgement tone is genuine. The tone arrives after band-pass filtering and demodulation, so the 21.945 kHz carrier is already gone. What remains is a square-ish tone of nominally 77 Hz. The block first synchronises the tone to the system clock and removes short glitches. It then measures each period, from one rising edge to the next, and the high time within that period, both in clock cycles.

A period is accepted only if two conditions hold. Its frequency must be within ±10 % of 77 Hz, and its duty ratio must lie between 25 % and 75 % inclusive. The limits are fixed cycle counts worked out when the design is built, so no division takes place at run time.

The valid flag goes high after a run of consecutive accepted periods. It drops on the first rejected period, or when no edge arrives for too long. While the flag is high, the block drives a square wave of about 20 kHz, which feeds an external charge pump that energises a relay coil. The square wave never starts or stops in the middle of a pulse.

Top module: `ack_tone_validator`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it until the tone qualifies, `ack_valid` and `pump_drive` are both 0.
- R2: The period is the number of clock cycles between consecutive filtered rising edges. It is acceptable when it lies in [ceil(100·CLK_HZ/(TONE_HZ·(100+TOL_PCT))), floor(100·CLK_HZ/(TONE_HZ·(100−TOL_PCT)))], which is the 77 Hz ±10 % window. A period outside this range is rejected.
- R3: The high time is the number of filtered-high cycles in the period. The duty test passes when 100·high ≥ DUTY_LO_PCT·period and 100·high ≤ DUTY_HI_PCT·period (25 % and 75 %, both bounds inclusive).
- R4: `ack_valid` rises after GOOD_CYCLES (default 3) consecutive accepted periods. The first filtered rising edge after reset or after a timeout only starts a measurement; it completes no period.
- R5: A single rejected period clears `ack_valid`.
- R6: If no filtered rising edge arrives for 2·(maximum period) cycles, `ack_valid` clears. This covers a stuck-high or stuck-low input. It stays clear until R4 is met again.
- R7: A level change of the input is accepted only after it has held for GLITCH_CYCLES consecutive synchronised samples. Shorter pulses of either polarity do not affect measurement.
- R8: While `ack_valid` is 1, `pump_drive` is a square wave whose period is 2·HALF cycles, with HALF = floor(CLK_HZ/(2·PUMP_HZ)), at least 1. While `ack_valid` is 0, `pump_drive` rests at 0.
- R9: Every high phase of `pump_drive` lasts exactly HALF cycles, including the phase in progress when `ack_valid` falls. After enable, the first high phase follows a full low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_in | input | 1 | Demodulated acknowledgement tone, asynchronous |
| ack_valid | output | 1 | Tone judged genuine |
| pump_drive | output | 1 | Charge-pump drive square wave, low when idle |

## Verification
The hardest state to reach is a run of accepted periods that contains a period sitting exactly on an acceptance boundary. To reach it, the bench builds tones whose period or high time is the smallest or largest accepted count. It follows each with a normal period and samples the flag just after the next edge. Each boundary is paired with the count one step outside it, applied while the flag is high, so the drop shows directly. Glitch-laden periods, and inputs held high or low past the timeout, are applied while the flag is high. A behavioural model with its own integer timestamps predicts both outputs on every clock.

// File: rtl/ack_val_pkg.sv
// Package: compile-time helpers that turn frequencies and tolerances
// into cycle-count limits. Assumes all arguments are positive and that
// tol_pct is below 100.
package ack_val_pkg;

    // Shortest acceptable period (cycles), rounded up.
    function automatic longint min_period(longint clk_hz, longint tone_hz, longint tol_pct);
        longint num;
        longint den;
        num = clk_hz * 100;
        den = tone_hz * (100 + tol_pct);
        return (num + den - 1) / den;
    endfunction

    // Longest acceptable period (cycles), rounded down.
    function automatic longint max_period(longint clk_hz, longint tone_hz, longint tol_pct);
        longint num;
        longint den;
        num = clk_hz * 100;
        den = tone_hz * (100 - tol_pct);
        return num / den;
    endfunction

    // Half period of the pump drive in cycles, never below one.
    function automatic longint half_period(longint clk_hz, longint pump_hz);
        longint q;
        q = clk_hz / (2 * pump_hz);
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/ack_sync_filter.sv
// Module: two-flop synchroniser followed by a persistence filter.
// The filtered level follows the input only after the synchronised value
// has differed from it for GLITCH_CYCLES consecutive cycles. A one-cycle
// pulse marks each accepted low-to-high change; it is high in the same
// cycle the filtered level first reads 1.
// Assumes GLITCH_CYCLES >= 1.
module ack_sync_filter #(
    parameter int GLITCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int GW = $clog2(GLITCH_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic          rise_q;
    logic [GW-1:0] pers_q;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            pers_q  <= '0;
            rise_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (sync_q[1] != level_q) begin
                if (pers_q == GW'(GLITCH_CYCLES - 1)) begin
                    level_q <= sync_q[1];
                    pers_q  <= '0;
                    rise_q  <= sync_q[1];
                end else begin
                    pers_q <= pers_q + 1'b1;
                end
            end else begin
                pers_q <= '0;
            end
        end
    end

    assign level = level_q;
    assign rise  = rise_q;
endmodule

// File: rtl/ack_period_meter.sv
// Module: measures the period and high time of the filtered tone.
// On every rising pulse it reports the cycles since the previous rising
// pulse and the high cycles within them, but only once a previous edge
// has armed it. When TIMEOUT cycles pass with no edge it emits a timeout
// pulse and disarms, so the next edge only restarts measurement.
// Assumes TIMEOUT >= 2 and CW wide enough to hold TIMEOUT.
module ack_period_meter #(
    parameter longint TIMEOUT = 1000,
    parameter int     CW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          rise,
    output logic          meas_vld,
    output logic [CW-1:0] meas_per,
    output logic [CW-1:0] meas_hi,
    output logic          tmo
);
    logic [CW-1:0] per_q;
    logic [CW-1:0] hi_q;
    logic          armed_q;
    logic          expire;

    assign expire = !rise && (per_q == CW'(TIMEOUT - 1));

    // Count cycles and high cycles since the last edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            hi_q  <= '0;
        end else if (rise) begin
            per_q <= CW'(1);
            hi_q  <= CW'(1);
        end else begin
            if (per_q != CW'(TIMEOUT)) per_q <= per_q + 1'b1;
            if (level && hi_q != CW'(TIMEOUT)) hi_q <= hi_q + 1'b1;
        end
    end

    // Track whether a previous edge makes the next one a full period.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (rise)   armed_q <= 1'b1;
        else if (expire) armed_q <= 1'b0;
    end

    // Register the finished measurement and the timeout event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_vld <= 1'b0;
            meas_per <= '0;
            meas_hi  <= '0;
            tmo      <= 1'b0;
        end else begin
            meas_vld <= rise && armed_q;
            meas_per <= per_q;
            meas_hi  <= hi_q;
            tmo      <= expire;
        end
    end
endmodule

// File: rtl/ack_qualifier.sv
// Module: judges each measured period against the frequency window and
// the duty band, and keeps a saturating run of accepted periods. The
// valid flag rises when the run reaches GOOD_CYCLES. It clears on a
// rejected period or on a timeout.
// Assumes the duty test may use constant multiplies (no run-time division)
// and that GOOD_CYCLES >= 1.
module ack_qualifier #(
    parameter int     CW          = 10,
    parameter longint PER_LO      = 100,
    parameter longint PER_HI      = 200,
    parameter longint DUTY_LO_PCT = 25,
    parameter longint DUTY_HI_PCT = 75,
    parameter int     GOOD_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_vld,
    input  logic [CW-1:0] meas_per,
    input  logic [CW-1:0] meas_hi,
    input  logic          tmo,
    output logic          valid
);
    localparam int PW = CW + 7;
    localparam int RW = $clog2(GOOD_CYCLES + 1);

    logic [PW-1:0] hi_x100;
    logic [PW-1:0] floor_lim;
    logic [PW-1:0] ceil_lim;
    logic          per_ok;
    logic          duty_ok;
    logic          good;
    logic [RW-1:0] run_q;
    logic          valid_q;

    // Scale both sides of the duty comparison to whole percent.
    always_comb begin
        hi_x100   = PW'(meas_hi)  * PW'(100);
        floor_lim = PW'(meas_per) * PW'(DUTY_LO_PCT);
        ceil_lim  = PW'(meas_per) * PW'(DUTY_HI_PCT);
        per_ok    = (meas_per >= CW'(PER_LO)) && (meas_per <= CW'(PER_HI));
        duty_ok   = (hi_x100 >= floor_lim) && (hi_x100 <= ceil_lim);
        good      = per_ok && duty_ok;
    end

    // Update the run of accepted periods and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (tmo) begin
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (meas_vld) begin
            if (good) begin
                if (run_q != RW'(GOOD_CYCLES)) run_q <= run_q + 1'b1;
                valid_q <= (run_q >= RW'(GOOD_CYCLES - 1));
            end else begin
                run_q   <= '0;
                valid_q <= 1'b0;
            end
        end
    end

    assign valid = valid_q;
endmodule

// File: rtl/ack_pump_div.sv
// Module: divider that makes the charge-pump square wave. It runs while
// enabled or while a high phase is still in progress, so every pulse is
// complete. When idle it rests low with its counter cleared, so the first
// output pulse after enable follows a full low half.
// Assumes HALF >= 1.
module ack_pump_div #(
    parameter longint HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pump
);
    localparam int HW = $clog2(HALF + 1);

    logic [HW-1:0] cnt_q;
    logic          pump_q;

    // Toggle every HALF cycles; finish a high phase before stopping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pump_q <= 1'b0;
        end else if (enable || pump_q) begin
            if (cnt_q == HW'(HALF - 1)) begin
                cnt_q  <= '0;
                pump_q <= !pump_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q  <= '0;
            pump_q <= 1'b0;
        end
    end

    assign pump = pump_q;
endmodule

// File: rtl/ack_tone_validator.sv
// Module: top of the acknowledgement tone validator. It chains the input
// filter, the period meter, the qualifier and the pump divider. All cycle
// limits come from the frequency parameters when the design is built.
// Assumes CLK_HZ is far above both TONE_HZ and 2*PUMP_HZ.
module ack_tone_validator #(
    parameter longint CLK_HZ        = 50_000_000,
    parameter longint TONE_HZ       = 77,
    parameter longint TOL_PCT       = 10,
    parameter longint DUTY_LO_PCT   = 25,
    parameter longint DUTY_HI_PCT   = 75,
    parameter longint PUMP_HZ       = 20_000,
    parameter int     GOOD_CYCLES   = 3,
    parameter int     GLITCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_valid,
    output logic pump_drive
);
    localparam longint PER_LO     = ack_val_pkg::min_period(CLK_HZ, TONE_HZ, TOL_PCT);
    localparam longint PER_HI     = ack_val_pkg::max_period(CLK_HZ, TONE_HZ, TOL_PCT);
    localparam longint TIMEOUT    = 2 * PER_HI;
    localparam longint PUMP_HALF  = ack_val_pkg::half_period(CLK_HZ, PUMP_HZ);
    localparam int     CW         = $clog2(TIMEOUT + 1);

    logic          filt_level;
    logic          filt_rise;
    logic          meas_vld;
    logic [CW-1:0] meas_per;
    logic [CW-1:0] meas_hi;
    logic          tmo_pulse;

    ack_sync_filter #(
        .GLITCH_CYCLES(GLITCH_CYCLES)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ack_in),
        .level (filt_level),
        .rise  (filt_rise)
    );

    ack_period_meter #(
        .TIMEOUT(TIMEOUT),
        .CW     (CW)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (filt_level),
        .rise     (filt_rise),
        .meas_vld (meas_vld),
        .meas_per (meas_per),
        .meas_hi  (meas_hi),
        .tmo      (tmo_pulse)
    );

    ack_qualifier #(
        .CW         (CW),
        .PER_LO     (PER_LO),
        .PER_HI     (PER_HI),
        .DUTY_LO_PCT(DUTY_LO_PCT),
        .DUTY_HI_PCT(DUTY_HI_PCT),
        .GOOD_CYCLES(GOOD_CYCLES)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .meas_vld (meas_vld),
        .meas_per (meas_per),
        .meas_hi  (meas_hi),
        .tmo      (tmo_pulse),
        .valid    (ack_valid)
    );

    ack_pump_div #(
        .HALF(PUMP_HALF)
    ) u_pump (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ack_valid),
        .pump   (pump_drive)
    );
endmodule

// File: rtl/ack_tone_validator_chk.sv
// Module: assertion checker for the tone validator, bound to the top.
// It observes the outputs together with the meter's event pulses.
// Assumes HALF matches the pump divider's half period.
module ack_tone_validator_chk #(
    parameter longint HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic valid,
    input logic pump,
    input logic meas_vld,
    input logic tmo
);
    localparam int HW = $clog2(HALF + 2);

    logic [HW-1:0] high_len;

    // Length of the current high phase of the pump drive, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        high_len <= '0;
        else if (!pump)                    high_len <= '0;
        else if (high_len != HW'(HALF + 1)) high_len <= high_len + 1'b1;
    end

    // R4: the flag can only rise right after a completed measurement.
    p_rise_after_meas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(meas_vld));

    // R5: the flag only falls after a measurement or a timeout.
    p_fall_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(meas_vld || tmo));

    // R6: a timeout leaves the flag low.
    p_timeout_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !valid);

    // R8: an idle drive cannot start a pulse without the flag.
    p_idle_stays_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !pump) |=> !pump);

    // R9: every completed high phase lasts exactly HALF cycles.
    p_full_high_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump) |-> (high_len == HW'(HALF)));
endmodule

bind ack_tone_validator ack_tone_validator_chk #(
    .HALF(PUMP_HALF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (ack_valid),
    .pump     (pump_drive),
    .meas_vld (meas_vld),
    .tmo      (tmo_pulse)
);

// File: tb/sim_ack_tone_validator.sv
`timescale 1ns/1ps
// Bench: drives tones of chosen period and high time, compares both
// outputs on every clock against a behavioural timestamp model, and adds
// targeted checks at the acceptance boundaries. The frequency parameters
// are scaled so that one nominal period is 2000 cycles.
module sim_ack_tone_validator;
    localparam longint CLK_HZ = 154_000;
    localparam longint TONE   = 77;
    localparam longint PUMP   = 20_000;
    localparam int     G      = 4;
    localparam int     GOOD   = 3;
    localparam int     HALF   = 3;      // floor(154000 / 40000)
    localparam int     TMO    = 4444;   // twice the longest period 2222

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic valid_o;
    logic pump_o;

    always #2.5 clk = ~clk;

    ack_tone_validator #(
        .CLK_HZ(CLK_HZ), .TONE_HZ(TONE), .TOL_PCT(10),
        .DUTY_LO_PCT(25), .DUTY_HI_PCT(75), .PUMP_HZ(PUMP),
        .GOOD_CYCLES(GOOD), .GLITCH_CYCLES(G)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ack_in(din),
        .ack_valid(valid_o), .pump_drive(pump_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Acceptance rule written from the requirements: 77 Hz +-10 %, duty 1/4..3/4.
    function automatic bit accept(longint per, longint hi);
        bit f_ok;
        bit d_ok;
        f_ok = (per * TONE * 90 <= CLK_HZ * 100) && (per * TONE * 110 >= CLK_HZ * 100);
        d_ok = (4 * hi >= per) && (4 * hi <= 3 * per);
        return f_ok && d_ok;
    endfunction

    // Behavioural model state.
    bit  m_s1, m_s2, m_lvl, m_rise, m_armed;
    bit  m_pend, m_pgood, m_ptmo, m_valid, m_pump;
    int  m_pers, m_cyc, m_last, m_hi, m_run, m_pc;

    // Model: advance one clock, stages taken from output back to input.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_rise = 0; m_armed = 0;
            m_pend = 0; m_pgood = 0; m_ptmo = 0; m_valid = 0; m_pump = 0;
            m_pers = 0; m_cyc = 0; m_last = 0; m_hi = 0; m_run = 0; m_pc = 0;
        end else begin
            automatic int age = m_cyc - m_last;
            if (m_valid || m_pump) begin
                if (m_pc == HALF - 1) begin m_pc = 0; m_pump = !m_pump; end
                else m_pc++;
            end else begin
                m_pc = 0; m_pump = 0;
            end
            if (m_ptmo) begin
                m_run = 0; m_valid = 0;
            end else if (m_pend) begin
                if (m_pgood) begin
                    m_valid = (m_run + 1 >= GOOD);
                    if (m_run < GOOD) m_run++;
                end else begin
                    m_run = 0; m_valid = 0;
                end
            end
            m_ptmo  = (age == TMO - 1) && !m_rise;
            m_pend  = m_rise && m_armed;
            m_pgood = accept(age, m_hi);
            if (m_rise) begin
                m_armed = 1; m_last = m_cyc; m_hi = 1;
            end else begin
                if (m_lvl) m_hi++;
                if (m_ptmo) m_armed = 0;
            end
            m_rise = 0;
            if (m_s2 != m_lvl) begin
                if (m_pers == G - 1) begin m_lvl = m_s2; m_pers = 0; m_rise = m_s2; end
                else m_pers++;
            end else begin
                m_pers = 0;
            end
            m_s2 = m_s1;
            m_s1 = din;
            m_cyc++;
        end
    end

    // Every clock: compare outputs with the model; measure pump high phases.
    bit prev_pump = 0;
    int high_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(valid_o === m_valid, "R4 valid vs model", valid_o, m_valid);
            check(pump_o === m_pump, "R8 pump vs model", pump_o, m_pump);
            if (pump_o) high_run++;
            else if (prev_pump) begin
                check(high_run == HALF, "R9 high phase length", high_run, HALF);
                high_run = 0;
            end
            prev_pump = pump_o;
        end
    end

    task automatic hold(bit v, int n);
        din = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic tone(int d, int h);
        hold(1, h);
        hold(0, d - h);
    endtask

    // Start a tone, check the flag 20 cycles after its rising edge, and
    // optionally count pump rising edges over 600 cycles.
    task automatic tone_chk(int d, int h, bit exp, string req, bit count_pump);
        int used;
        used = 20;
        hold(1, 20);
        check(valid_o == exp, req, valid_o, exp);
        if (count_pump) begin
            int rises;
            bit pv;
            rises = 0;
            pv = pump_o;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (pump_o && !pv) rises++;
                pv = pump_o;
            end
            check(rises == 600 / (2 * HALF), "R8 pump rate", rises, 600 / (2 * HALF));
            used = 620;
        end
        hold(1, h - used);
        hold(0, d - h);
    endtask

    // A 2000-cycle, 50 % period carrying sub-threshold pulses of both polarities.
    task automatic tone_glitchy();
        hold(1, 500); hold(0, 3); hold(1, 497);
        hold(0, 400); hold(1, 3); hold(0, 597);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(valid_o == 0, "R1 valid in reset", valid_o, 0);
        check(pump_o == 0, "R1 pump in reset", pump_o, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(valid_o == 0 && pump_o == 0, "R1 idle after reset", {valid_o, pump_o}, 0);

        // R4: first edge arms, three measured periods needed.
        tone(2000, 1000); tone(2000, 1000);
        tone_chk(2000, 1000, 0, "R4 two periods not enough", 0);
        tone_chk(2000, 1000, 1, "R4 three periods qualify", 1);

        // R3/R5: duty just under 25 %, then exactly 25 %.
        tone(2000, 499);
        tone_chk(2000, 1000, 0, "R5 duty 24.95% clears valid", 0);
        tone(2000, 500); tone(2000, 500);
        tone_chk(2000, 1000, 1, "R3 duty 25% accepted", 0);

        // R3: duty just over 75 %, then exactly 75 %.
        tone(2000, 1501);
        tone_chk(2000, 1000, 0, "R3 duty 75.05% rejected", 0);
        tone(2000, 1500); tone(2000, 1500);
        tone_chk(2000, 1000, 1, "R3 duty 75% accepted", 0);

        // R2: shortest period boundary (1819 in, 1818 out).
        tone(1818, 909);
        tone_chk(2000, 1000, 0, "R2 period 1818 rejected", 0);
        tone(1819, 910); tone(1819, 910);
        tone_chk(2000, 1000, 1, "R2 period 1819 accepted", 0);

        // R2: longest period boundary (2222 in, 2223 out).
        tone(2223, 1111);
        tone_chk(2000, 1000, 0, "R2 period 2223 rejected", 0);
        tone(2222, 1111); tone(2222, 1111);
        tone_chk(2000, 1000, 1, "R2 period 2222 accepted", 0);

        // R7: 3-cycle pulses of either polarity leave measurement intact.
        tone_glitchy(); tone_glitchy();
        tone_chk(2000, 1000, 1, "R7 glitches ignored", 0);

        // R6: stuck high.
        hold(1, 4000);
        check(valid_o == 1, "R6 still valid before timeout", valid_o, 1);
        hold(1, 2000);
        check(valid_o == 0, "R6 stuck high clears valid", valid_o, 0);
        check(pump_o == 0, "R8 pump idle without valid", pump_o, 0);
        hold(0, 1000);

        // R4 after timeout, then R6 stuck low.
        tone(2000, 1000); tone(2000, 1000); tone(2000, 1000);
        tone_chk(2000, 1000, 1, "R4 requalify after timeout", 0);
        hold(1, 1000);
        hold(0, 3000);
        check(valid_o == 1, "R6 still valid before timeout", valid_o, 1);
        hold(0, 3000);
        check(valid_o == 0, "R6 stuck low clears valid", valid_o, 0);

        // R4: first edge after timeout only arms.
        tone(2000, 1000); tone(2000, 1000);
        tone_chk(2000, 1000, 0, "R4 edge after timeout only arms", 0);
        tone_chk(2000, 1000, 1, "R4 qualifies on third period", 1);
        hold(0, 100);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 180_000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule